// File: doc/BRIEF.md
# Four-Slot Pulse-Width Bit Encoder

This block converts a burst of data bits into a pulse-width coded waveform on one serial line. Every bit takes four slots of equal length. The first slot is always low and the last slot is always high. The two middle slots carry the bit value, so a one appears as a short low pulse and a zero as a long low pulse. A prescaler on the system clock sets the slot length. With the default of 48 cycles per slot at 48 MHz, each slot lasts 1 µs.

Operation has two phases. While the line is idle, a host fills an internal first-in, first-out bit store through a valid/ready write port. A start strobe then launches the burst. The encoder sends the stored bits one after another with no gap and stops when the store is empty. It picks the four-slot shape of each bit once, at the bit boundary. During the bit it drives the line to that shape's value in every slot, even when the value does not change.

The controller has two states. `ST_IDLE` holds the line high and accepts writes. `ST_SEND` sends bits and refuses writes. The transitions are:
- **launch**: `ST_IDLE` to `ST_SEND`, taken on start when the store is not empty.
- **next-bit**: `ST_SEND` to `ST_SEND`, taken at the end of a bit when more bits are stored.
- **drain**: `ST_SEND` to `ST_IDLE`, taken at the end of a bit when the store is empty. This transition raises the done pulse.

Top module: `pwbit_encoder`

## Requirements
- R1: After reset, and whenever no burst is active, `line_out` is 1, `busy` is 0 and `done` is 0. `wr_ready` is 1 after reset.
- R2: Each bit occupies four consecutive slots (slot 0 to slot 3). Slot 0 drives 0, slot 3 drives 1, and slots 1 and 2 drive the bit value. A 1 is therefore sent as 0,1,1,1 and a 0 as 0,0,0,1.
- R3: Each slot lasts `SLOT_CYCLES` clock cycles. The default is 48.
- R4: Bits are sent in the order they were written, the first written being sent first.
- R5: Slot 0 of the first bit begins in the cycle after the edge that samples `start`. Slot 0 of each later bit begins in the cycle right after slot 3 of the previous bit ends, with no idle cycle between bits.
- R6: `busy` is 1 from the cycle after start until the end of the last slot of the last bit. In the following cycle, `busy` is 0 and `done` is 1 for exactly one cycle.
- R7: `wr_ready` is 0 while `busy` is 1 and while the store holds `DEPTH` bits. A write offered while `wr_ready` is 0 is discarded.
- R8: A start with an empty store is ignored: `busy` stays 0 and no `done` pulse appears. A start during a burst has no effect on the waveform.
- R9: After a burst completes, the store is empty, so a following start with no new writes is ignored.
- R10: The store capacity is `DEPTH` bits. The default is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request for one data bit |
| wr_bit | input | 1 | Data bit to store |
| wr_ready | output | 1 | Store can accept a bit (idle and not full) |
| start | input | 1 | Launch strobe for a burst |
| line_out | output | 1 | Pulse-width coded serial line |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the last slot of a burst |

## Verification
The bench uses a small configuration (3 cycles per slot, 8-bit store) and sends every bit pattern of lengths one to four. Comparing each cycle of the line against arithmetically computed slot values separates errors in bit order, slot shape, slot length and bit-to-bit gaps. Longer bursts, including a full store plus one refused extra bit, exercise the capacity limit and the draining at the end. A write attempted mid-burst and a start repeated mid-burst, each followed by a start with no new data, show whether the block refuses data while busy and ignores an empty launch. A single burst on a default-sized instance confirms the 48-cycle slot and the 32-bit store.

// File: rtl/pwbit_pkg.sv
package pwbit_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } enc_state_e;

    // Line values for slots 0..3, with bit n of the result holding slot n.
    function automatic logic [3:0] shape_of(input logic value);
        return {1'b1, value, value, 1'b0};
    endfunction

endpackage

// File: rtl/pwbit_slot_timer.sv
module pwbit_slot_timer #(
    parameter int SLOT_CYCLES = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic [1:0] slot_idx,
    output logic       bit_end
);
    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] cyc_q;
    logic [1:0]    slot_q;
    logic          slot_end;

    assign slot_end = run && (cyc_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cyc_q  <= '0;
            slot_q <= '0;
        end else if (slot_end) begin
            cyc_q  <= '0;
            slot_q <= slot_q + 2'd1;
        end else begin
            cyc_q  <= cyc_q + 1'b1;
        end
    end

    assign slot_idx = slot_q;
    assign bit_end  = slot_end && (slot_q == 2'd3);

endmodule

// File: rtl/pwbit_fifo.sv
module pwbit_fifo #(
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic        push_bit,
    input  logic        pop,
    output logic        head_bit,
    output logic [AW:0] fill,
    output logic        full,
    output logic        empty
);
    logic [DEPTH-1:0] mem;
    logic [AW-1:0]    wp_q, rp_q;
    logic [AW:0]      cnt_q;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= push_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= step(wp_q);
            if (do_pop)  rp_q <= step(rp_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_bit = mem[rp_q];
    assign fill     = cnt_q;

endmodule

// File: rtl/pwbit_encoder.sv
module pwbit_encoder
    import pwbit_pkg::*;
#(
    parameter int SLOT_CYCLES = 48,
    parameter int DEPTH       = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic wr_bit,
    output logic wr_ready,
    input  logic start,
    output logic line_out,
    output logic busy,
    output logic done
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    enc_state_e  state_q, state_d;
    logic [3:0]  shape_q;
    logic        done_q;
    logic [1:0]  slot_idx;
    logic        bit_end;
    logic        head_bit, fifo_full, fifo_empty;
    logic [AW:0] fill_cnt;
    logic        launch, pop, drain;

    pwbit_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == ST_SEND),
        .slot_idx (slot_idx),
        .bit_end  (bit_end)
    );

    pwbit_fifo #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_valid && wr_ready),
        .push_bit (wr_bit),
        .pop      (pop),
        .head_bit (head_bit),
        .fill     (fill_cnt),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    assign launch = (state_q == ST_IDLE) && start && !fifo_empty;
    assign drain  = (state_q == ST_SEND) && bit_end && fifo_empty;
    assign pop    = launch || ((state_q == ST_SEND) && bit_end && !fifo_empty);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_SEND;
            ST_SEND: if (drain)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shape_q <= 4'b1111;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= drain;
            if (pop) shape_q <= shape_of(head_bit);
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SEND: begin
                line_out = shape_q[slot_idx];
                busy     = 1'b1;
                wr_ready = 1'b0;
            end
            default: begin
                line_out = 1'b1;
                busy     = 1'b0;
                wr_ready = !fifo_full;
            end
        endcase
        done = done_q;
    end

endmodule

// File: rtl/pwbit_checker.sv
module pwbit_checker #(
    parameter int SLOT_CYCLES = 48,
    parameter int DEPTH       = 32,
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BCW = $clog2(4 * SLOT_CYCLES + 1)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        line_out,
    input logic        busy,
    input logic        done,
    input logic        wr_ready,
    input logic [AW:0] fill
);
    logic [BCW-1:0] bcyc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) bcyc_q <= '0;
        else if (bcyc_q == BCW'(4 * SLOT_CYCLES - 1)) bcyc_q <= '0;
        else bcyc_q <= bcyc_q + 1'b1;
    end

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);

    // R2
    first_slot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcyc_q < BCW'(SLOT_CYCLES)) |-> !line_out);

    // R2
    last_slot_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcyc_q >= BCW'(3 * SLOT_CYCLES)) |-> line_out);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_ready);

    // R8
    empty_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && fill == '0) |=> !busy);

    // R10
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= (AW+1)'(DEPTH));

endmodule

bind pwbit_encoder pwbit_checker #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .DEPTH       (DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .line_out (line_out),
    .busy     (busy),
    .done     (done),
    .wr_ready (wr_ready),
    .fill     (fill_cnt)
);

// File: tb/sim_pwbit_encoder.sv
module sim_pwbit_encoder;
    localparam int S0 = 3;
    localparam int D0 = 8;
    localparam int S1 = 48;
    localparam int D1 = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wv [2];
    logic wb [2];
    logic st [2];
    logic rdy [2];
    logic line [2];
    logic bsy [2];
    logic dn [2];

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwbit_encoder #(.SLOT_CYCLES(S0), .DEPTH(D0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wv[0]), .wr_bit(wb[0]),
        .wr_ready(rdy[0]), .start(st[0]), .line_out(line[0]),
        .busy(bsy[0]), .done(dn[0]));

    pwbit_encoder u1 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wv[1]), .wr_bit(wb[1]),
        .wr_ready(rdy[1]), .start(st[1]), .line_out(line[1]),
        .busy(bsy[1]), .done(dn[1]));

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Writes n bits (pat[0] first), launches, and compares every cycle.
    // sent = number of bits the store is expected to have accepted.
    task automatic burst(input int sel, input int S, input int n,
                         input logic [63:0] pat, input int sent, input bit poke);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wv[sel] = 1'b1;
            wb[sel] = pat[i];
        end
        @(negedge clk);
        wv[sel] = 1'b0;
        if (n >= sent && sent > 0 && n > 1)
            check("R7 ready low when store full", int'(rdy[sel]), (n >= (sel == 0 ? D0 : D1)) ? 0 : 1);
        st[sel] = 1'b1;
        @(negedge clk);
        st[sel] = 1'b0;
        for (int k = 0; k < sent * 4 * S; k++) begin
            int slot = (k / S) % 4;
            int b    = k / (4 * S);
            int exp  = (slot == 0) ? 0 : (slot == 3) ? 1 : int'(pat[b]);
            check("R2 R3 R4 R5 line value", int'(line[sel]), exp);
            check("R6 busy during burst", int'(bsy[sel]), 1);
            if (k == 0) check("R7 ready low while busy", int'(rdy[sel]), 0);
            if (poke && k == 0) begin
                wv[sel] = 1'b1;
                wb[sel] = 1'b1;
            end
            if (poke && k == 1) begin
                wv[sel] = 1'b0;
                st[sel] = 1'b1;
            end
            if (poke && k == 2) st[sel] = 1'b0;
            @(negedge clk);
        end
        if (sent > 0) begin
            check("R6 done pulse", int'(dn[sel]), 1);
            check("R6 busy low at done", int'(bsy[sel]), 0);
            check("R1 line idle high", int'(line[sel]), 1);
            @(negedge clk);
            check("R6 done one cycle", int'(dn[sel]), 0);
        end
        // R8 R9: start with nothing new written must be ignored
        st[sel] = 1'b1;
        @(negedge clk);
        st[sel] = 1'b0;
        check("R8 R9 empty start ignored busy", int'(bsy[sel]), 0);
        @(negedge clk);
        check("R8 R9 empty start no done", int'(dn[sel]), 0);
        check("R1 ready high idle", int'(rdy[sel]), 1);
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            wv[s] = 1'b0; wb[s] = 1'b0; st[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            check("R1 reset line", int'(line[s]), 1);
            check("R1 reset busy", int'(bsy[s]), 0);
            check("R1 reset done", int'(dn[s]), 0);
            check("R1 reset ready", int'(rdy[s]), 1);
        end
        // R8: start on empty store right after reset
        burst(0, S0, 0, 64'd0, 0, 1'b0);
        // R2 R4: every pattern of length 1..4
        for (int n = 1; n <= 4; n++)
            for (int p = 0; p < (1 << n); p++)
                burst(0, S0, n, 64'(p), n, (p % 2) == 1);
        // longer bursts up to capacity
        burst(0, S0, 5, 64'h16, 5, 1'b1);
        burst(0, S0, 7, 64'h5A, 7, 1'b0);
        burst(0, S0, D0, 64'hC9, D0, 1'b1);
        // R7 R10: one extra bit beyond capacity is refused
        burst(0, S0, D0 + 1, 64'h1B3, D0, 1'b0);
        // R3 R10: default configuration, full store
        burst(1, S1, D1, 64'hA5C3_0F96, D1, 1'b1);
        burst(1, S1, D1 + 1, 64'h1_3C5A_F00F, D1, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule